// File: doc/BRIEF.md
# Audio Link Transmit Slot Stream

This block carries one outbound sample stream (PCM audio or modem) of a serial audio link controller. A small FIFO of samples is refilled from memory through a DMA request and acknowledge pair. Data is therefore waiting before the codec asks for it. The frame serializer raises a slot strobe once per frame, at the point where this stream's slot is due. With it comes the codec's request bit for that slot, already extracted from the incoming serial line.

When the stream is enabled and its slot is requested, the block takes the oldest sample from the FIFO. It presents that sample with the slot-valid tag set. A request that finds the FIFO empty sends a blank, untagged slot and raises a sticky underrun flag. Two separate enables control the stream: one for slot transmission and one for DMA refill. Dropping the slot enable discards everything that is queued.

Top module: `slot_tx_stream`

## Requirements
- R1: While reset is held with the DMA enable low, slotValid, slotData, dmaReq and underrunErr are all 0 and the FIFO is empty.
- R2: A cycle with dmaAck high and fewer than DEPTH (8) stored samples appends dmaData to the FIFO. An acknowledge while the FIFO holds DEPTH samples is discarded. Samples leave in arrival order.
- R3: dmaReq is high only while dmaEn is high and the FIFO is not full. It rises once occupancy is at most DEPTH/2 (4). Once high, it stays high until the FIFO is full or dmaEn drops.
- R4: A slotStrobe cycle with slotEn and slotReq high and a non-empty FIFO removes the oldest sample. From the next cycle, slotData carries that sample and slotValid is 1.
- R5: A slotStrobe cycle with slotReq low, or with slotEn low, gives slotValid 0 and slotData 0 from the next cycle. It removes no sample and leaves underrunErr unchanged.
- R6: A slotStrobe cycle with slotEn and slotReq high while the FIFO is empty gives slotValid 0 and slotData 0 from the next cycle and sets underrunErr. Emptiness is judged before any DMA write in that same cycle.
- R7: underrunErr stays set until a cycle with errClr high. If a new underrun and errClr coincide, the flag stays set.
- R8: In the cycle after slotEn goes from 1 to 0, the FIFO is emptied, and a DMA write in that cycle is dropped. Writes while slotEn is low are otherwise accepted, so the FIFO can be filled before the stream is enabled.
- R9: slotData and slotValid change only on the clock edge that ends a slotStrobe cycle. Between strobes they hold.
- R10: A DMA write and a slot removal in the same cycle both take effect, and occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotEn | input | 1 | Slot transmission enable for this stream |
| dmaEn | input | 1 | DMA refill enable for this stream |
| dmaReq | output | 1 | Refill request to the DMA controller |
| dmaAck | input | 1 | DMA write strobe, one sample per cycle |
| dmaData | input | 20 | Sample written on dmaAck |
| slotStrobe | input | 1 | One-cycle pulse marking this stream's slot in the frame |
| slotReq | input | 1 | Codec request bit for this slot, valid with slotStrobe |
| slotData | output | 20 | Sample presented to the serializer |
| slotValid | output | 1 | Slot-valid tag for slotData |
| underrunErr | output | 1 | Sticky underrun flag |
| errClr | input | 1 | Write-one-to-clear for underrunErr |

## Verification
Three pairs of events can land in the same cycle: a DMA write with a slot removal, a DMA write with a request on an empty FIFO, and a new underrun with an error clear. The directed phases drive each pair together on purpose, with the acknowledge and strobe in one cycle. A long random phase follows that keeps occupancy near both ends. A behavioural queue model in the bench decides each outcome from the requirement rules. It judges emptiness on pre-write occupancy and lets the set win over the clear. Every output is compared against this model on every clock.

// File: rtl/slot_tx_pkg.sv
package slot_tx_pkg;

  // strobes issued by the control half to the datapath each cycle
  typedef struct packed {
    logic push;       // append the DMA word
    logic pop;        // remove the head sample
    logic flush;      // discard all stored samples
    logic load;       // update the slot output registers
    logic sendValid;  // output the head sample with the tag set
  } fifoCmd_t;

endpackage

// File: rtl/slot_tx_datapath.sv
module slot_tx_datapath
  import slot_tx_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  fifoCmd_t                        cmd,
  input  logic [DATA_W-1:0]               wrData,
  output logic [DATA_W-1:0]               slotData,
  output logic                            slotValid,
  output logic [$clog2(DEPTH+1)-1:0]      count,
  output logic                            empty,
  output logic                            full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  // storage carries no reset; occupancy alone defines which entries are live
  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= bumpPtr(wrPtr);
      if (cmd.pop)  rdPtr <= bumpPtr(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // slot outputs, refreshed once per slot strobe and held otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotData  <= '0;
      slotValid <= 1'b0;
    end else if (cmd.load) begin
      slotData  <= cmd.sendValid ? mem[rdPtr] : '0;
      slotValid <= cmd.sendValid;
    end
  end

endmodule

// File: rtl/slot_tx_ctrl.sv
module slot_tx_ctrl
  import slot_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        slotEn,
  input  logic                        dmaEn,
  input  logic                        dmaAck,
  input  logic                        slotStrobe,
  input  logic                        slotReq,
  input  logic                        errClr,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  input  logic                        empty,
  input  logic                        full,
  output fifoCmd_t                    cmd,
  output logic                        dmaReq,
  output logic                        underrunErr
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  logic slotEnQ;
  logic reqQ;
  logic served;
  logic flushNow;
  logic underrunNow;

  assign flushNow    = slotEnQ & ~slotEn;
  assign served      = slotStrobe & slotEn & slotReq;
  assign underrunNow = served & empty;

  always_comb begin
    cmd           = '0;
    cmd.flush     = flushNow;
    cmd.push      = dmaAck & ~full & ~flushNow;
    cmd.pop       = served & ~empty;
    cmd.load      = slotStrobe;
    cmd.sendValid = served & ~empty;
  end

  // refill request with hysteresis: raised at half free, kept until full
  assign dmaReq = dmaEn & ~full & ((count <= HALF) | reqQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotEnQ     <= 1'b0;
      reqQ        <= 1'b0;
      underrunErr <= 1'b0;
    end else begin
      slotEnQ <= slotEn;
      reqQ    <= dmaReq;
      if (underrunNow)  underrunErr <= 1'b1;
      else if (errClr)  underrunErr <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_tx_stream.sv
module slot_tx_stream
  import slot_tx_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotEn,
  input  logic              dmaEn,
  output logic              dmaReq,
  input  logic              dmaAck,
  input  logic [DATA_W-1:0] dmaData,
  input  logic              slotStrobe,
  input  logic              slotReq,
  output logic [DATA_W-1:0] slotData,
  output logic              slotValid,
  output logic              underrunErr,
  input  logic              errClr
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoCmd_t         cmd;
  logic [CNT_W-1:0] fillCount;
  logic             fifoEmpty;
  logic             fifoFull;

  slot_tx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .slotEn      (slotEn),
    .dmaEn       (dmaEn),
    .dmaAck      (dmaAck),
    .slotStrobe  (slotStrobe),
    .slotReq     (slotReq),
    .errClr      (errClr),
    .count       (fillCount),
    .empty       (fifoEmpty),
    .full        (fifoFull),
    .cmd         (cmd),
    .dmaReq      (dmaReq),
    .underrunErr (underrunErr)
  );

  slot_tx_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wrData    (dmaData),
    .slotData  (slotData),
    .slotValid (slotValid),
    .count     (fillCount),
    .empty     (fifoEmpty),
    .full      (fifoFull)
  );

endmodule

// File: rtl/slot_tx_checker.sv
module slot_tx_checker #(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        slotEn,
  input logic                        slotReq,
  input logic                        slotStrobe,
  input logic                        errClr,
  input logic                        dmaReq,
  input logic                        slotValid,
  input logic [DATA_W-1:0]           slotData,
  input logic                        underrunErr,
  input logic [$clog2(DEPTH+1)-1:0]  count
);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH);

  assert_no_req_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (count == DEPTH) |-> !dmaReq);

  assert_valid_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotValid) |-> $past(slotStrobe && slotEn && slotReq));

  assert_underrun_blank_R6: assert property (@(posedge clk) disable iff (!rstN)
    (slotStrobe && slotEn && slotReq && count == 0)
      |=> (!slotValid && slotData == '0 && underrunErr));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (underrunErr && !errClr) |=> underrunErr);

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(slotEn) && $past(rstN)) |=> (count == 0));

  assert_output_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !slotStrobe |=> ($stable(slotValid) && $stable(slotData)));

endmodule

bind slot_tx_stream slot_tx_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .slotEn      (slotEn),
  .slotReq     (slotReq),
  .slotStrobe  (slotStrobe),
  .errClr      (errClr),
  .dmaReq      (dmaReq),
  .slotValid   (slotValid),
  .slotData    (slotData),
  .underrunErr (underrunErr),
  .count       (fillCount)
);

// File: tb/sim_slot_tx_stream.sv
module sim_slot_tx_stream;

  localparam int PERIOD = 10;
  localparam int DATA_W = 20;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              slotEn = 1'b0;
  logic              dmaEn = 1'b0;
  logic              dmaReq;
  logic              dmaAck = 1'b0;
  logic [DATA_W-1:0] dmaData = '0;
  logic              slotStrobe = 1'b0;
  logic              slotReq = 1'b0;
  logic [DATA_W-1:0] slotData;
  logic              slotValid;
  logic              underrunErr;
  logic              errClr = 1'b0;

  int    checks = 0;
  int    fails = 0;
  string phase = "R1 reset";
  logic [DATA_W-1:0] seqVal = 20'h00100;

  always #(PERIOD/2) clk = ~clk;

  slot_tx_stream #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .dmaEn(dmaEn), .dmaReq(dmaReq),
    .dmaAck(dmaAck), .dmaData(dmaData), .slotStrobe(slotStrobe),
    .slotReq(slotReq), .slotData(slotData), .slotValid(slotValid),
    .underrunErr(underrunErr), .errClr(errClr)
  );

  // behavioural reference model
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] mData = '0;
  logic mValid = 1'b0, mErr = 1'b0, mPrevReq = 1'b0, mEnQ = 1'b0;
  logic wasFull, flushing, reqNow, errSet;

  function automatic logic expReq();
    return dmaEn && (q.size() != DEPTH) && (q.size() <= DEPTH/2 || mPrevReq);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      mData = '0; mValid = 1'b0; mErr = 1'b0; mPrevReq = 1'b0; mEnQ = 1'b0;
    end else begin
      wasFull  = (q.size() == DEPTH);
      flushing = mEnQ && !slotEn;
      reqNow   = expReq();
      errSet   = 1'b0;
      if (slotStrobe) begin
        if (slotEn && slotReq) begin
          if (q.size() > 0) begin mData = q.pop_front(); mValid = 1'b1; end
          else begin mData = '0; mValid = 1'b0; errSet = 1'b1; end
        end else begin
          mData = '0; mValid = 1'b0;
        end
      end
      if (errSet) mErr = 1'b1;
      else if (errClr) mErr = 1'b0;
      if (dmaAck && !wasFull && !flushing) q.push_back(dmaData);
      if (flushing) q.delete();
      mPrevReq = reqNow;
      mEnQ = slotEn;
    end
  end

  task automatic cmp(input string what, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cmp("dmaReq", DATA_W'(dmaReq), DATA_W'(expReq()));
      cmp("slotValid", DATA_W'(slotValid), DATA_W'(mValid));
      cmp("slotData", slotData, mData);
      cmp("underrunErr", DATA_W'(underrunErr), DATA_W'(mErr));
    end
  end

  task automatic step(input logic a, input logic s, input logic r, input logic c);
    @(posedge clk);
    #2;
    dmaAck = a; slotStrobe = s; slotReq = r; errClr = c;
    if (a) begin dmaData = seqVal; seqVal = seqVal + 20'h00011; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    cmp("reset slotValid", DATA_W'(slotValid), '0);
    cmp("reset slotData", slotData, '0);
    cmp("reset dmaReq", DATA_W'(dmaReq), '0);
    cmp("reset underrunErr", DATA_W'(underrunErr), '0);
    rstN = 1'b1;
    idle(2);

    phase = "R2 R3 fill past full";
    slotEn = 1'b1; dmaEn = 1'b1;
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    idle(3);

    phase = "R4 R9 R3 ordered sends";
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0);
      idle(3);
    end

    phase = "R5 strobe without request";
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0);
      idle(2);
    end

    phase = "R10 write and send together";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    idle(2);

    phase = "R6 drain to underrun";
    dmaEn = 1'b0;
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    idle(2);
    phase = "R6 R10 write on empty request";
    step(1'b1, 1'b1, 1'b1, 1'b0);
    idle(2);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    idle(2);

    phase = "R7 clear and set over clear";
    step(1'b0, 1'b0, 1'b0, 1'b1);
    idle(2);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    idle(2);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    idle(2);

    phase = "R8 flush on disable";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #2; slotEn = 1'b0;
    dmaAck = 1'b1; dmaData = seqVal; seqVal = seqVal + 20'h00011;
    idle(1);
    phase = "R5 R8 request while disabled";
    step(1'b0, 1'b1, 1'b1, 1'b0);
    idle(1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #2; slotEn = 1'b1; dmaAck = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    idle(2);

    phase = "R3 refill enable toggling";
    dmaEn = 1'b1; idle(3);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    dmaEn = 1'b0; idle(3);
    dmaEn = 1'b1; idle(3);

    phase = "R2 R4 R6 R7 R8 R10 mixed traffic";
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #2;
      dmaAck = dmaReq ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 7) == 0);
      dmaData = seqVal; seqVal = seqVal + 20'h00011;
      slotStrobe = ($urandom_range(0, 2) == 0);
      slotReq = ($urandom_range(0, 5) != 0);
      errClr = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 99) == 0) slotEn = ~slotEn;
      if ($urandom_range(0, 49) == 0) dmaEn = ~dmaEn;
    end
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule